// File: doc/BRIEF.md
# Integer Register File

This block is the integer register file of a small scalar core. It holds thirty-two 32-bit registers, addressed by 5-bit register numbers, and serves two independent read ports and one write port in every cycle. The decode stage drives the two source selectors and receives both operands combinationally, in the same cycle. The writeback stage presents a destination number, data and an enable, and the file captures them at the next rising clock edge.

Register 0 is hard-wired to zero. It has no storage, and every write aimed at it is discarded. The reset is active-low and asynchronous. It clears every register except register 2, which it loads with 0xFFFFFFF0 so that the stack pointer starts at the top of memory.

Top module: `rf_top`

## Requirements
- R1: The file holds 32 registers of 32 bits, selected by 5-bit numbers; a value written to register n (n = 1..31) is kept and read back unchanged until n is written again or reset occurs.
- R2: A write takes effect only at a rising clock edge at which wr_en_i is 1; with wr_en_i at 0 no register changes.
- R3: Register 0 reads as 0x00000000 on both ports at all times, and writes to register 0 have no effect.
- R4: While rst_ni is 0 (asynchronous, active-low), every register reads 0 except register 2, which reads 0xFFFFFFF0.
- R5: Reset takes priority over a write: a write presented while rst_ni is 0 is lost.
- R6: rd_a_data_o reflects the register chosen by rd_a_sel_i and rd_b_data_o the register chosen by rd_b_sel_i, combinationally, with no clock edge needed after a selector change.
- R7: There is no write-to-read bypass: a port reading the register being written shows the old value until the clock edge, and the new value after it.
- R8: When both selectors are equal, both ports return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_sel_i | input | 5 | Register number for read port A |
| rd_b_sel_i | input | 5 | Register number for read port B |
| wr_sel_i | input | 5 | Destination register number |
| wr_data_i | input | 32 | Data to write |
| wr_en_i | input | 1 | Write enable |
| rd_a_data_o | output | 32 | Read data of port A |
| rd_b_data_o | output | 32 | Read data of port B |

## Verification
Read results are due in the same cycle as the selector change. The bench therefore changes selectors away from the clock edge and samples one time step later, with no edge in between. A write becomes visible exactly one rising edge after it is presented. The bench drives writes on the falling edge and samples just after the following rising edge, and it also samples once before that edge to confirm that the old value is still held. Reset effects are checked while rst_ni is still low and again after it is released, since the reset acts without a clock.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
  localparam int unsigned SP_IDX   = 2;
  localparam logic [DATA_W-1:0] SP_INIT = 32'hFFFF_FFF0;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
#(
  parameter int unsigned N  = NUM_REGS,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  input  logic          en_i,
  output logic [N-1:0]  wen_o
);
  assign wen_o[0] = 1'b0;  // slot 0 never written

  for (genvar i = 1; i < N; i++) begin : g_dec
    assign wen_o[i] = en_i && (sel_i == SW'(i));
  end

  // R2
  onehot_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wen_o));

  // R2
  idle_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (wen_o == '0));
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int unsigned N       = NUM_REGS,
  parameter int unsigned W       = DATA_W,
  parameter int unsigned SP      = SP_IDX,
  parameter logic [W-1:0] SP_VAL = SP_INIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        wen_i,
  input  logic [W-1:0]        wdata_i,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_flop
      localparam logic [W-1:0] RST_VAL = (i == SP) ? SP_VAL : '0;
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= RST_VAL;
        else if (wen_i[i]) q <= wdata_i;
      end
      assign regs_o[i] = q;
    end
  end

  // R2
  hold_no_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i == '0) |=> $stable(regs_o));

  // R4
  sp_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (regs_o[SP] == SP_VAL));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int unsigned N  = NUM_REGS,
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic [N-1:0][W-1:0] regs_i,
  input  logic [SW-1:0]       sel_i,
  output logic [W-1:0]        rdata_o
);
  always_comb begin
    if (sel_i == '0) rdata_o = '0;  // zero forced here, not stored
    else             rdata_o = regs_i[sel_i];
  end
endmodule

// File: rtl/rf_top.sv
module rf_top
  import rf_pkg::*;
#(
  parameter int unsigned N  = NUM_REGS,
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] rd_a_sel_i,
  input  logic [SW-1:0] rd_b_sel_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          wr_en_i,
  output logic [W-1:0]  rd_a_data_o,
  output logic [W-1:0]  rd_b_data_o
);
  logic [N-1:0]        wen;
  logic [N-1:0][W-1:0] regs;

  rf_wr_decode #(.N(N), .SW(SW)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (wr_sel_i),
    .en_i   (wr_en_i),
    .wen_o  (wen)
  );

  rf_storage #(.N(N), .W(W), .SP(SP_IDX), .SP_VAL(W'(SP_INIT))) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wen_i   (wen),
    .wdata_i (wr_data_i),
    .regs_o  (regs)
  );

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [SW-1:0] sel;
    logic [W-1:0]  dat;
    assign sel = (p == 0) ? rd_a_sel_i : rd_b_sel_i;
    rf_read_port #(.N(N), .W(W), .SW(SW)) u_rd (
      .regs_i  (regs),
      .sel_i   (sel),
      .rdata_o (dat)
    );
  end
  assign rd_a_data_o = g_rd[0].dat;
  assign rd_b_data_o = g_rd[1].dat;

  // R3
  zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sel_i == '0) |-> (rd_a_data_o == '0));

  // R3
  zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_sel_i == '0) |-> (rd_b_data_o == '0));

  // R8
  same_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sel_i == rd_b_sel_i) |-> (rd_a_data_o == rd_b_data_o));

  // R1
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != '0) |=>
      ((rd_a_sel_i != $past(wr_sel_i)) || (rd_a_data_o == $past(wr_data_i))));
endmodule

// File: tb/rf_top_tb.sv
module rf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SP_EXP = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sel_a = '0, sel_b = '0, wsel = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic [31:0] dat_a, dat_b;
  logic [31:0] model [32];
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_sel_i(sel_a), .rd_b_sel_i(sel_b),
    .wr_sel_i(wsel), .wr_data_i(wdata), .wr_en_i(wen),
    .rd_a_data_o(dat_a), .rd_b_data_o(dat_b)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'(i) * 32'h0111_1111) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) model[i] = (i == 2) ? SP_EXP : '0;
  endtask

  task automatic read_pair(input string req, input int a, input int b);
    sel_a = 5'(a); sel_b = 5'(b);
    #1;
    chk(req, dat_a, model[a]);
    chk(req, dat_b, model[b]);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) read_pair(req, i, 31 - i);
  endtask

  task automatic write(input int idx, input logic [31:0] d, input logic en);
    @(negedge clk);
    wsel = 5'(idx); wdata = d; wen = en;
    @(posedge clk);
    #1;
    wen = 1'b0;
    if (en && idx != 0) model[idx] = d;
  endtask

  initial begin
    model_reset();
    // R4: values visible while reset is held, no edge needed
    #3;
    sweep("R4 reset held");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sweep("R4 after release");

    // R1 R6: fill every register, read back in two orders
    for (int i = 0; i < 32; i++) write(i, pat(i, 1), 1'b1);
    sweep("R1 R6 fill");
    for (int i = 0; i < 32; i++) read_pair("R6 cross", (i * 7) % 32, (i * 13 + 5) % 32);

    // R3: writes to register 0 discarded
    write(0, 32'hFFFF_FFFF, 1'b1);
    read_pair("R3 zero", 0, 0);
    write(0, 32'h1234_5678, 1'b1);
    read_pair("R3 zero", 0, 1);

    // R2: enable low leaves every register unchanged
    for (int i = 1; i < 32; i += 3) write(i, ~pat(i, 1), 1'b0);
    sweep("R2 no enable");

    // R8: both ports on the same register
    for (int i = 0; i < 32; i++) begin
      read_pair("R8 same", i, i);
      chk("R8 equal", dat_a, dat_b);
    end

    // R7: old value before edge, new after
    @(negedge clk);
    sel_a = 5'd9; sel_b = 5'd9;
    wsel = 5'd9; wdata = 32'hCAFE_0009; wen = 1'b1;
    #1;
    chk("R7 before edge", dat_a, model[9]);
    chk("R7 before edge", dat_b, model[9]);
    @(posedge clk); #1;
    wen = 1'b0; model[9] = 32'hCAFE_0009;
    chk("R7 after edge", dat_a, 32'hCAFE_0009);
    chk("R7 after edge", dat_b, 32'hCAFE_0009);

    // R1: overwrite a second round, check retention
    for (int i = 31; i >= 0; i--) write(i, pat(i, 2), 1'b1);
    sweep("R1 rewrite");

    // R4 R5: reset with a write pending across an edge
    @(negedge clk);
    wsel = 5'd2; wdata = 32'h0000_1111; wen = 1'b1;
    rst_n = 1'b0;
    model_reset();
    #1;
    sweep("R4 async");
    @(posedge clk); #1;
    read_pair("R5 priority", 2, 2);
    @(negedge clk); wen = 1'b0; rst_n = 1'b1;
    sweep("R5 after release");

    // R1: write after reset still works, including register 2
    write(2, 32'h8000_0000, 1'b1);
    write(31, 32'h0000_0001, 1'b1);
    sweep("R1 after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule